// File: doc/BRIEF.md
# ATM Cell Transmit Receiver (PHY side, 32-bit word bus)

This block sits on the physical-layer side of a 32-bit cell transmit bus. The ATM layer presents one 32-bit word per clock and qualifies it with an active-low enable. For every qualified word the block checks the accompanying parity bit against a programmable sense, odd or even. It uses an active-high start-of-cell marker to find cell boundaries, assembles 13-word cells (52 bytes, no header check byte) and commits only complete cells to a four-cell store. A downstream consumer pops committed words in order, and the first word of each cell is flagged.

Back-pressure reaches the ATM layer through one flow-control output. Two configuration bits decide what that pin means. One selects a word-level "full" meaning or a cell-level "room for a cell" meaning. The other selects the polarity. A start-of-cell marker that arrives in the middle of a cell drops the partial cell and raises a sticky short-cell flag. Words that arrive with no cell open, or with the store out of space, are dropped.

Top module: `utx_cell_sink`

## Requirements
- R1: A word is taken only on a rising clock edge where `tx_en_n` is 0. When `tx_en_n` is 1, the data, parity and start-of-cell inputs change no output and no stored state.
- R2: `par_err` is 1 in the cycle after a taken word whose 32 data bits XOR the parity bit give the wrong value. The expected value is 1 when `cfg_par_even` is 0 (odd, the reset setting) and 0 when `cfg_par_even` is 1. Otherwise `par_err` is 0.
- R3: A word taken without start-of-cell is discarded if no cell is open. No cell is open after reset, after a cell completes, or after an overflow.
- R4: A cell becomes readable only when its 13th word is taken. `rd_valid` is 1 while at least one committed word is unread. Each `rd_en` with `rd_valid` set pops one word, in arrival order. `rd_sof` is 1 on the first word of each cell.
- R5: A start-of-cell that arrives while a partial cell holds one or more words discards that partial cell and sets `runt_flag`. The flag stays 1 until reset. The marked word then starts a new cell.
- R6: Free space is 52 minus the unread committed words minus the words of the open partial cell. With `cfg_cell_level` = 0, the internal full condition is true when free space is 4 or less.
- R7: With `cfg_cell_level` = 1, the internal cell-available condition is true when free space is 13 or more.
- R8: With `cfg_pol_inv` = 0, `flow_out` is the inverse of full in word mode and equal to cell-available in cell mode. With `cfg_pol_inv` = 1, both polarities are reversed.
- R9: A word that finds no free location (a start-of-cell word when 52 committed words are unread, or any other word when free space is 0) is not stored. The open partial cell is discarded and the block waits for the next start-of-cell.
- R10: After reset `rd_valid`, `runt_flag` and `par_err` are 0 and free space is 52.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ATM-layer transfer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en_n | input | 1 | Active-low word qualifier |
| tx_data | input | 32 | Cell word from the ATM layer |
| tx_par | input | 1 | Parity bit over tx_data |
| tx_soc | input | 1 | Start-of-cell marker, active high |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd |
| cfg_cell_level | input | 1 | 1 selects cell-available meaning, 0 selects full |
| cfg_pol_inv | input | 1 | Reverses the flow-control polarity |
| flow_out | output | 1 | Flow-control indication to the ATM layer |
| par_err | output | 1 | Parity error pulse, one cycle after the word |
| runt_flag | output | 1 | Sticky short-cell status |
| rd_en | input | 1 | Pop one committed word |
| rd_valid | output | 1 | Committed data is available |
| rd_data | output | 32 | Word at the head of the store |
| rd_sof | output | 1 | Head word is the first word of a cell |

## Verification
The bench targets a start-of-cell that lands on word 12 of an open cell. A block that commits early would deliver a 12-word cell here, and one that misses it would leave `runt_flag` low. It fills the store to the last location and then sends a start-of-cell word and also a word in the middle of a cell. A block with a wrong free-space count would overwrite unread data, and one with an off-by-one full threshold would drop a legal word or raise `flow_out` one word late or early. It switches the parity sense, the flow meaning and the polarity while traffic runs, and it drives junk with start-of-cell set on idle cycles. A block that samples while disabled would open a cell there.

// File: rtl/utx_pkg.sv
package utx_pkg;

   typedef enum logic {
      FLOW_WORD = 1'b0,
      FLOW_CELL = 1'b1
   } flow_mode_e;

   // Number of bits needed to hold the value n.
   function automatic int bits_for(input int n);
      int r;
      r = 1;
      while ((1 << r) <= n) r++;
      return r;
   endfunction

endpackage

// File: rtl/utx_parity_chk.sv
module utx_parity_chk #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic [DATA_W-1:0] data,
   input  logic              par,
   input  logic              even_sel,
   output logic              par_err
);
   localparam int LANES = DATA_W / 8;

   logic [LANES-1:0] lane_x;
   logic             total;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_x[g] = ^data[8*g +: 8];
   end

   assign total = (^lane_x) ^ par;

   always_ff @(posedge clk) begin
      if (!rst_n) par_err <= 1'b0;
      else        par_err <= acc && (total != !even_sel);
   end

   AST_PERR_ONLY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      par_err |-> $past(acc)); // R2

endmodule

// File: rtl/utx_cell_assembler.sv
module utx_cell_assembler #(
   parameter int DATA_W     = 32,
   parameter int CELL_WORDS = 13,
   parameter int DEPTH      = 52,
   parameter int PTR_W      = 6,
   parameter int CNT_W      = 6,
   parameter int PART_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              soc,
   input  logic [DATA_W-1:0] data,
   input  logic              pop,
   output logic              we,
   output logic [PTR_W-1:0]  waddr,
   output logic [DATA_W:0]   wword,
   output logic [CNT_W-1:0]  commit_words,
   output logic [CNT_W-1:0]  free_words,
   output logic              runt_flag
);
   localparam logic [CNT_W-1:0]  DEPTH_C = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0]  CELL_C  = CNT_W'(CELL_WORDS);
   localparam logic [PART_W-1:0] LAST_C  = PART_W'(CELL_WORDS - 1);

   logic [PTR_W-1:0]  base_ptr, base_n;
   logic [PART_W-1:0] part_cnt, part_n;
   logic [CNT_W-1:0]  commit_n, used;
   logic              hunt, hunt_n, runt_n, do_commit;
   logic [PTR_W-1:0]  hole;

   function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] a,
                                                 input logic [CNT_W-1:0] b);
      logic [CNT_W:0] s;
      s = (CNT_W+1)'(a) + (CNT_W+1)'(b);
      if (s >= (CNT_W+1)'(DEPTH)) s = s - (CNT_W+1)'(DEPTH);
      return s[PTR_W-1:0];
   endfunction

   assign used       = commit_words + CNT_W'(part_cnt);
   assign free_words = DEPTH_C - used;
   assign hole       = wrap_add(base_ptr, CNT_W'(part_cnt));

   always_comb begin
      base_n    = base_ptr;
      part_n    = part_cnt;
      hunt_n    = hunt;
      runt_n    = runt_flag;
      do_commit = 1'b0;
      we        = 1'b0;
      waddr     = hole;
      wword     = {1'b0, data};
      if (acc) begin
         if (soc) begin
            runt_n = runt_flag | (part_cnt != '0);
            part_n = '0;
            if (commit_words < DEPTH_C) begin
               we     = 1'b1;
               waddr  = base_ptr;
               wword  = {1'b1, data};
               part_n = PART_W'(1);
               hunt_n = 1'b0;
            end else begin
               hunt_n = 1'b1;
            end
         end else if (!hunt) begin
            if (used < DEPTH_C) begin
               we = 1'b1;
               if (part_cnt == LAST_C) begin
                  do_commit = 1'b1;
                  part_n    = '0;
                  base_n    = wrap_add(base_ptr, CELL_C);
                  hunt_n    = 1'b1;
               end else begin
                  part_n = part_cnt + PART_W'(1);
               end
            end else begin
               part_n = '0;
               hunt_n = 1'b1;
            end
         end
      end
      commit_n = commit_words + (do_commit ? CELL_C : '0) - (pop ? CNT_W'(1) : '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_ptr     <= '0;
         part_cnt     <= '0;
         hunt         <= 1'b1;
         runt_flag    <= 1'b0;
         commit_words <= '0;
      end else begin
         base_ptr     <= base_n;
         part_cnt     <= part_n;
         hunt         <= hunt_n;
         runt_flag    <= runt_n;
         commit_words <= commit_n;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      used <= DEPTH_C); // R9
   AST_PART_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      part_cnt < PART_W'(CELL_WORDS)); // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> $stable(part_cnt) && $stable(base_ptr)); // R1
   AST_RUNT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      runt_flag |=> runt_flag); // R5

endmodule

// File: rtl/utx_cell_store.sv
module utx_cell_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 52,
   parameter int PTR_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [PTR_W-1:0]  waddr,
   input  logic [DATA_W:0]   wword,
   input  logic              pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_sof
);
   logic [DATA_W:0]  mem [DEPTH];
   logic [PTR_W-1:0] rd_ptr;

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wword;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   rd_ptr <= '0;
      else if (pop) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
   end

   assign rd_data = mem[rd_ptr][DATA_W-1:0];
   assign rd_sof  = mem[rd_ptr][DATA_W];

endmodule

// File: rtl/utx_flow_ctl.sv
module utx_flow_ctl #(
   parameter int CELL_WORDS  = 13,
   parameter int FULL_MARGIN = 4,
   parameter int CNT_W       = 6,
   parameter bit FLOW_REG    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] free_words,
   input  logic             cell_level,
   input  logic             pol_inv,
   output logic             flow_out
);
   import utx_pkg::*;

   flow_mode_e mode;
   logic       full_c, cav_c, flow_c;

   assign mode   = cell_level ? FLOW_CELL : FLOW_WORD;
   assign full_c = free_words <= CNT_W'(FULL_MARGIN);
   assign cav_c  = free_words >= CNT_W'(CELL_WORDS);
   assign flow_c = (mode == FLOW_CELL) ? (cav_c ^ pol_inv) : !(full_c ^ pol_inv);

   if (FLOW_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) flow_out <= !pol_inv;
         else        flow_out <= flow_c;
      end
   end else begin : g_comb
      assign flow_out = flow_c;
   end

endmodule

// File: rtl/utx_cell_sink.sv
module utx_cell_sink #(
   parameter int DATA_W      = 32,
   parameter int CELL_WORDS  = 13,
   parameter int NUM_CELLS   = 4,
   parameter int FULL_MARGIN = 4,
   parameter bit FLOW_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en_n,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_par,
   input  logic              tx_soc,
   input  logic              cfg_par_even,
   input  logic              cfg_cell_level,
   input  logic              cfg_pol_inv,
   output logic              flow_out,
   output logic              par_err,
   output logic              runt_flag,
   input  logic              rd_en,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_sof
);
   localparam int DEPTH  = CELL_WORDS * NUM_CELLS;
   localparam int PTR_W  = utx_pkg::bits_for(DEPTH - 1);
   localparam int CNT_W  = utx_pkg::bits_for(DEPTH);
   localparam int PART_W = utx_pkg::bits_for(CELL_WORDS);

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_chk_w
      $error("utx_cell_sink: DATA_W must be a non-zero multiple of 8");
   end
   if (CELL_WORDS < 2) begin : g_chk_c
      $error("utx_cell_sink: CELL_WORDS must be at least 2");
   end
   if (NUM_CELLS < 1) begin : g_chk_n
      $error("utx_cell_sink: NUM_CELLS must be at least 1");
   end
   if (FULL_MARGIN >= DEPTH) begin : g_chk_m
      $error("utx_cell_sink: FULL_MARGIN must be below the store depth");
   end

   logic              acc, pop, we;
   logic [PTR_W-1:0]  waddr;
   logic [DATA_W:0]   wword;
   logic [CNT_W-1:0]  commit_words, free_words;

   assign acc      = !tx_en_n;
   assign rd_valid = commit_words != '0;
   assign pop      = rd_en && rd_valid;

   utx_parity_chk #(.DATA_W(DATA_W)) u_par (
      .clk(clk), .rst_n(rst_n), .acc(acc), .data(tx_data), .par(tx_par),
      .even_sel(cfg_par_even), .par_err(par_err));

   utx_cell_assembler #(
      .DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS), .DEPTH(DEPTH),
      .PTR_W(PTR_W), .CNT_W(CNT_W), .PART_W(PART_W)
   ) u_asm (
      .clk(clk), .rst_n(rst_n), .acc(acc), .soc(tx_soc), .data(tx_data),
      .pop(pop), .we(we), .waddr(waddr), .wword(wword),
      .commit_words(commit_words), .free_words(free_words),
      .runt_flag(runt_flag));

   utx_cell_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wword(wword),
      .pop(pop), .rd_data(rd_data), .rd_sof(rd_sof));

   utx_flow_ctl #(
      .CELL_WORDS(CELL_WORDS), .FULL_MARGIN(FULL_MARGIN),
      .CNT_W(CNT_W), .FLOW_REG(FLOW_REG)
   ) u_flow (
      .clk(clk), .rst_n(rst_n), .free_words(free_words),
      .cell_level(cfg_cell_level), .pol_inv(cfg_pol_inv), .flow_out(flow_out));

   AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_valid) |=> !$rose(rd_valid) || $past(acc)); // R4

endmodule

// File: tb/tb_utx_cell_sink.sv
`timescale 1ns/1ps
module tb_utx_cell_sink;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n, tx_en_n, tx_par, tx_soc, rd_en;
   logic [31:0] tx_data;
   logic        cfg_par_even, cfg_cell_level, cfg_pol_inv;
   logic        flow_out, par_err, runt_flag, rd_valid, rd_sof;
   logic [31:0] rd_data;

   utx_cell_sink dut (
      .clk(clk), .rst_n(rst_n), .tx_en_n(tx_en_n), .tx_data(tx_data),
      .tx_par(tx_par), .tx_soc(tx_soc), .cfg_par_even(cfg_par_even),
      .cfg_cell_level(cfg_cell_level), .cfg_pol_inv(cfg_pol_inv),
      .flow_out(flow_out), .par_err(par_err), .runt_flag(runt_flag),
      .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_sof(rd_sof));

   int n_tests = 0;
   int n_fail  = 0;
   int seq     = 0;
   string phase = "R10";

   // reference model state
   logic [31:0] mq[$];
   bit          ms[$];
   logic [31:0] pq[$];
   bit          m_hunt = 1'b1;
   bit          m_runt = 1'b0;
   bit          m_perr = 1'b0;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s (%s) %s actual=%h expected=%h", req, phase, what, act, exp);
      end
   endtask

   task automatic compare();
      int  fr;
      bit  full, cav, ef;
      string rq;
      fr   = 52 - mq.size() - pq.size();
      full = (fr <= 4);
      cav  = (fr >= 13);
      ef   = cfg_cell_level ? (cav ^ cfg_pol_inv) : !(full ^ cfg_pol_inv);
      rq   = cfg_pol_inv ? "R8" : (cfg_cell_level ? "R7" : "R6");
      chk(rq, "flow_out", 32'(flow_out), 32'(ef));
      chk("R4", "rd_valid", 32'(rd_valid), 32'(mq.size() != 0));
      if (mq.size() != 0) begin
         chk("R4", "rd_data", rd_data, mq[0]);
         chk("R4", "rd_sof", 32'(rd_sof), 32'(ms[0]));
      end
      chk("R5", "runt_flag", 32'(runt_flag), 32'(m_runt));
      chk("R2", "par_err", 32'(par_err), 32'(m_perr));
   endtask

   task automatic model_update(bit en_n, logic [31:0] d, bit p, bit soc, bit rd);
      int pc, pp;
      pc = mq.size();
      pp = pq.size();
      m_perr = !en_n && ((^{d, p}) != !cfg_par_even);
      if (rd && pc > 0) begin
         void'(mq.pop_front());
         void'(ms.pop_front());
      end
      if (!en_n) begin
         if (soc) begin
            if (pp != 0) m_runt = 1'b1;
            pq.delete();
            if (pc < 52) begin pq.push_back(d); m_hunt = 1'b0; end
            else m_hunt = 1'b1;
         end else if (!m_hunt) begin
            if (pc + pp < 52) begin
               pq.push_back(d);
               if (pq.size() == 13) begin
                  foreach (pq[k]) begin mq.push_back(pq[k]); ms.push_back(k == 0); end
                  pq.delete();
                  m_hunt = 1'b1;
               end
            end else begin
               pq.delete();
               m_hunt = 1'b1;
            end
         end
      end
   endtask

   task automatic step(bit en_n, logic [31:0] d, bit p, bit soc, bit rd);
      @(negedge clk);
      compare();
      tx_en_n = en_n; tx_data = d; tx_par = p; tx_soc = soc; rd_en = rd;
      model_update(en_n, d, p, soc, rd);
   endtask

   task automatic set_cfg(bit ev, bit cl, bit pi);
      @(negedge clk);
      compare();
      cfg_par_even = ev; cfg_cell_level = cl; cfg_pol_inv = pi;
      tx_en_n = 1'b1; tx_soc = 1'b0; rd_en = 1'b0;
      model_update(1'b1, tx_data, tx_par, 1'b0, 1'b0);
   endtask

   task automatic send_word(bit soc, bit bad, bit rd);
      logic [31:0] d;
      bit p;
      seq++;
      d = 32'h5A00_0000 ^ (32'(seq) * 32'h0100_0193);
      p = cfg_par_even ? (^d) : !(^d);
      step(1'b0, d, p ^ bad, soc, rd);
   endtask

   task automatic send_cell(int bad_idx, bit rd);
      for (int i = 0; i < 13; i++) send_word(i == 0, i == bad_idx, rd);
   endtask

   task automatic idle(int n, bit rd);
      for (int i = 0; i < n; i++) step(1'b1, 32'hDEAD_BEEF, 1'b1, 1'b1, rd);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; tx_en_n = 1'b1; tx_data = '0; tx_par = 1'b0; tx_soc = 1'b0;
      rd_en = 1'b0; cfg_par_even = 1'b0; cfg_cell_level = 1'b0; cfg_pol_inv = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R10: reset state seen at the ports
      phase = "R10";
      @(negedge clk);
      chk("R10", "rd_valid", 32'(rd_valid), 32'd0);
      chk("R10", "runt_flag", 32'(runt_flag), 32'd0);
      chk("R10", "par_err", 32'(par_err), 32'd0);
      chk("R10", "flow_out", 32'(flow_out), 32'd1);

      // R3: words with no open cell are dropped
      phase = "R3";
      for (int i = 0; i < 4; i++) send_word(1'b0, 1'b0, 1'b0);
      // R1: idle cycles with junk and start-of-cell set
      phase = "R1";
      idle(3, 1'b0);
      phase = "R4";
      send_cell(-1, 1'b0);
      phase = "R3";
      for (int i = 0; i < 3; i++) send_word(1'b0, 1'b0, 1'b0);
      phase = "R1";
      send_word(1'b1, 1'b0, 1'b0);
      idle(2, 1'b0);
      for (int i = 0; i < 12; i++) send_word(1'b0, 1'b0, 1'b0);

      // R2: odd then even parity errors
      phase = "R2";
      send_cell(3, 1'b1);
      set_cfg(1'b1, 1'b0, 1'b0);
      send_cell(7, 1'b1);
      send_cell(0, 1'b0);
      idle(40, 1'b1);

      // R5: short cells, including one cut at word 12
      phase = "R5";
      set_cfg(1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 5; i++) send_word(i == 0, 1'b0, 1'b0);
      send_cell(-1, 1'b0);
      for (int i = 0; i < 12; i++) send_word(i == 0, 1'b0, 1'b1);
      send_cell(-1, 1'b1);
      idle(30, 1'b1);

      // R6/R9: fill the store, then overflow
      phase = "R6";
      for (int c = 0; c < 4; c++) send_cell(-1, 1'b0);
      phase = "R9";
      send_cell(-1, 1'b0);
      step(1'b1, 32'h0, 1'b0, 1'b0, 1'b1);
      send_cell(-1, 1'b0);
      idle(3, 1'b0);

      // R7/R8: cell-level meaning and both polarities while draining
      phase = "R7";
      set_cfg(1'b0, 1'b1, 1'b0);
      idle(20, 1'b1);
      send_cell(-1, 1'b1);
      phase = "R8";
      set_cfg(1'b0, 1'b1, 1'b1);
      idle(10, 1'b1);
      send_cell(-1, 1'b0);
      set_cfg(1'b0, 1'b0, 1'b1);
      for (int c = 0; c < 3; c++) send_cell(-1, 1'b0);
      idle(70, 1'b1);
      @(negedge clk);
      compare();

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule